// File: doc/BRIEF.md
# Single-Level Interrupt Entry Controller

This block manages the one maskable interrupt of a 12-bit word-addressed processor that has no stack. It holds the interrupt-enable flag and takes enable, disable and skip-then-enable requests from instruction decode. At each instruction boundary it samples a level-sensitive request line. When the flag allows it, the block takes over the memory port for a short entry sequence. It writes the current program counter into a fixed save word, reads the handler address from a fixed vector word, and hands that address to the fetch logic with a one-cycle load strobe.

Accepting an interrupt clears the enable flag, so handlers are not nested. A handler returns by issuing the enable request and then an indirect jump through the save word. Enabling is deferred until the instruction after the enable has finished. As a result, that return jump always completes before a request that is still pending is taken again. The request logic on the device side lies outside this block.

Top module: `intr_entry`

## Requirements
- R1: After reset the enable flag is clear and `busy`, `memReq`, `pcLoad` and `skip` are all 0.
- R2: While the enable flag is clear, a high `irq` at an instruction boundary (`instrDone` = 1) starts no entry: `busy` and `memReq` stay 0.
- R3: A high `irq` in cycles where `instrDone` is 0 starts no entry, even when interrupts are enabled.
- R4: An enable request (`ionReq` or `skonReq`) takes effect with a delay. The first boundary after it, which ends the enabling instruction, does not accept `irq`. The second boundary, which ends the following instruction, does accept it.
- R5: A disable request (`iofReq`) clears the enable flag and also cancels an enable that is still waiting. After it, no boundary accepts `irq` until a new enable request arrives.
- R6: An accepted boundary raises `busy` in the next cycle. The first memory access is a write (`memWe` = 1) to address 0x000 of the `curPc` value sampled at that boundary. `memReq`, `memWe`, `memAddr` and `memWdata` are held until `memAck` is seen.
- R7: After the save write is acknowledged, the block issues a read (`memWe` = 0) of address 0x001 and holds it until `memAck`. `memRdata` is taken in the acknowledge cycle.
- R8: In the cycle after the read acknowledge, `pcLoad` is 1 for exactly one cycle, and `newPc` carries the word that was read.
- R9: Entry clears the enable flag. A boundary with `irq` high after the entry completes is not accepted unless a new enable request arrives first.
- R10: In the cycle `skonReq` is high, `skip` is 1 exactly when the enable flag was already set. `skip` is 0 whenever `skonReq` is 0.
- R11: `busy` stays 1 from the cycle after the accepted boundary through the `pcLoad` cycle, and is 0 in the cycle after `pcLoad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Level interrupt request |
| instrDone | input | 1 | Instruction boundary strobe |
| ionReq | input | 1 | Enable request from decode |
| iofReq | input | 1 | Disable request from decode |
| skonReq | input | 1 | Skip-if-enabled, then enable, request |
| curPc | input | 12 | Address of the next instruction |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 12 | Memory word address |
| memWdata | output | 12 | Write data |
| memRdata | input | 12 | Read data, valid with memAck |
| memAck | input | 1 | Access completes at this clock edge |
| newPc | output | 12 | Handler address for the fetch unit |
| pcLoad | output | 1 | Load newPc into the program counter |
| skip | output | 1 | Skip the next instruction |
| busy | output | 1 | Entry sequence in progress |

## Verification
The assertions assume that the decode strobes `ionReq`, `iofReq` and `skonReq` are single-cycle pulses. They also assume these strobes never coincide with `instrDone` and do not arrive while `busy` is high. They further assume that `memAck` is raised only in response to a pending `memReq` and that `memRdata` is valid in that same cycle. The bench drives each strobe for exactly one cycle in the middle of an instruction, with boundaries issued as separate pulses. Its memory model acknowledges only a pending request, after a configurable number of wait cycles, and drops the acknowledge in the following cycle.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_VEC  = 2'd2,
    ST_LOAD = 2'd3
  } entState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capPc;   // sample curPc at the accepted boundary
    logic capVec;  // sample read data on the vector acknowledge
    logic selVec;  // address the vector word instead of the save word
    logic wrMem;   // current access is a write
  } dpCtl_t;

endpackage

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_entry_pkg::*;
#(
  parameter int ARM_DELAY = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   irq,
  input  logic   instrDone,
  input  logic   ionReq,
  input  logic   iofReq,
  input  logic   skonReq,
  input  logic   memAck,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   pcLoad,
  output logic   skip,
  output logic   busy
);
  localparam int CW = $clog2(ARM_DELAY + 1);
  localparam logic [CW-1:0] ARM_LOAD = CW'(ARM_DELAY);
  localparam logic [CW-1:0] ARM_LAST = CW'(1);

  entState_t state, stateNxt;
  logic          intEn;
  logic [CW-1:0] armCnt;
  logic          effEn;
  logic          accept;

  // the boundary that would arm the flag may already take the interrupt
  assign effEn  = intEn || (armCnt == ARM_LAST);
  assign accept = (state == ST_IDLE) && instrDone && irq && effEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn  <= 1'b0;
      armCnt <= '0;
    end else if (accept || iofReq) begin
      intEn  <= 1'b0;
      armCnt <= '0;
    end else if (ionReq || skonReq) begin
      armCnt <= ARM_LOAD;
    end else if (instrDone && (armCnt != '0)) begin
      armCnt <= armCnt - ARM_LAST;
      if (armCnt == ARM_LAST) intEn <= 1'b1;
    end
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (accept) stateNxt = ST_SAVE;
      ST_SAVE: if (memAck) stateNxt = ST_VEC;
      ST_VEC:  if (memAck) stateNxt = ST_LOAD;
      ST_LOAD: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl.capPc  = accept;
    ctl.capVec = (state == ST_VEC) && memAck;
    ctl.selVec = (state == ST_VEC);
    ctl.wrMem  = (state == ST_SAVE);
  end

  assign memReq = (state == ST_SAVE) || (state == ST_VEC);
  assign pcLoad = (state == ST_LOAD);
  assign busy   = (state != ST_IDLE);
  assign skip   = skonReq && intEn;

endmodule

// File: rtl/intr_entry_dp.sv
module intr_entry_dp
  import intr_entry_pkg::*;
#(
  parameter int W         = 12,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtl_t       ctl,
  input  logic [W-1:0] curPc,
  input  logic [W-1:0] memRdata,
  output logic         memWe,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  output logic [W-1:0] newPc
);
  localparam logic [W-1:0] SAVE_WORD = W'(SAVE_ADDR);
  localparam logic [W-1:0] VEC_WORD  = W'(VEC_ADDR);

  logic [W-1:0] savedPc;
  logic [W-1:0] vecQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPc <= '0;
      vecQ    <= '0;
    end else begin
      if (ctl.capPc)  savedPc <= curPc;
      if (ctl.capVec) vecQ    <= memRdata;
    end
  end

  assign memWe    = ctl.wrMem;
  assign memAddr  = ctl.selVec ? VEC_WORD : SAVE_WORD;
  assign memWdata = savedPc;
  assign newPc    = vecQ;

endmodule

// File: rtl/intr_entry.sv
module intr_entry
  import intr_entry_pkg::*;
#(
  parameter int W         = 12,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1,
  parameter int ARM_DELAY = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         irq,
  input  logic         instrDone,
  input  logic         ionReq,
  input  logic         iofReq,
  input  logic         skonReq,
  input  logic [W-1:0] curPc,
  output logic         memReq,
  output logic         memWe,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  input  logic [W-1:0] memRdata,
  input  logic         memAck,
  output logic [W-1:0] newPc,
  output logic         pcLoad,
  output logic         skip,
  output logic         busy
);
  dpCtl_t ctl;

  intr_entry_ctrl #(.ARM_DELAY(ARM_DELAY)) u_ctrl (
    .clk(clk), .rstN(rstN), .irq(irq), .instrDone(instrDone),
    .ionReq(ionReq), .iofReq(iofReq), .skonReq(skonReq), .memAck(memAck),
    .ctl(ctl), .memReq(memReq), .pcLoad(pcLoad), .skip(skip), .busy(busy)
  );

  intr_entry_dp #(.W(W), .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curPc(curPc), .memRdata(memRdata),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .newPc(newPc)
  );

endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk #(
  parameter int W         = 12,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input logic         clk,
  input logic         rstN,
  input logic         irq,
  input logic         instrDone,
  input logic         skonReq,
  input logic [W-1:0] curPc,
  input logic         memReq,
  input logic         memWe,
  input logic [W-1:0] memAddr,
  input logic [W-1:0] memWdata,
  input logic [W-1:0] memRdata,
  input logic         memAck,
  input logic [W-1:0] newPc,
  input logic         pcLoad,
  input logic         skip,
  input logic         busy
);
  AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(instrDone) && $past(irq))); // R3
  AST_SAVE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (memReq && memWe && memWdata == $past(curPc))); // R6
  AST_SAVE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr == W'(SAVE_ADDR))); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata))); // R6
  AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (memAddr == W'(VEC_ADDR))); // R7
  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> ($past(memReq && memAck && !memWe) && newPc == $past(memRdata))); // R8
  AST_LOAD_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> (!busy && !pcLoad)); // R11
  AST_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> busy); // R11
  AST_SKIP_ONLY_SKON: assert property (@(posedge clk) disable iff (!rstN)
    skip |-> skonReq); // R10
endmodule

bind intr_entry intr_entry_chk #(.W(W), .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .instrDone(instrDone), .skonReq(skonReq),
  .curPc(curPc), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .newPc(newPc),
  .pcLoad(pcLoad), .skip(skip), .busy(busy)
);

// File: tb/intr_entry_tb.sv
module intr_entry_tb;
  localparam int W = 12;

  typedef struct {
    int           kind;   // 0 write, 1 read, 2 pc load
    logic [W-1:0] addr;
    logic [W-1:0] data;
    string        req;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irq = 1'b0, instrDone = 1'b0, ionReq = 1'b0, iofReq = 1'b0, skonReq = 1'b0;
  logic [W-1:0] curPc = '0;
  logic memReq, memWe, pcLoad, skip, busy;
  logic [W-1:0] memAddr, memWdata, newPc;
  logic [W-1:0] memRdata = '0;
  logic memAck = 1'b0;

  int checks = 0, fails = 0;
  int waitStates = 0, waitCnt = 0;
  logic [W-1:0] vecVal = '0;
  item_t expQ[$];

  always #4 clk = ~clk;

  intr_entry u_dut (
    .clk(clk), .rstN(rstN), .irq(irq), .instrDone(instrDone), .ionReq(ionReq),
    .iofReq(iofReq), .skonReq(skonReq), .curPc(curPc), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .newPc(newPc), .pcLoad(pcLoad), .skip(skip), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic item_t popExp(input int kind);
    item_t it;
    if (expQ.size() == 0) begin
      it.kind = -1; it.addr = '0; it.data = '0; it.req = "R2 unexpected";
    end else it = expQ.pop_front();
    if (it.kind != kind) it.kind = -1;
    return it;
  endfunction

  // memory model and monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (waitCnt < waitStates) waitCnt++;
        else begin
          item_t it;
          waitCnt = 0;
          it = popExp(memWe ? 0 : 1);
          check(it.kind >= 0, {it.req, " access kind"}, W'(memWe), W'(it.kind == 0));
          check(memAddr == it.addr, {it.req, " address"}, memAddr, it.addr);
          if (memWe) check(memWdata == it.data, {it.req, " saved pc"}, memWdata, it.data);
          memRdata = vecVal;
          memAck = 1'b1;
        end
      end
      if (pcLoad) begin
        item_t it;
        it = popExp(2);
        check(it.kind == 2 && newPc == it.data, "R8 newPc on load", newPc, it.data);
      end
    end
  end

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: ionReq = 1'b1;
      1: iofReq = 1'b1;
      default: skonReq = 1'b1;
    endcase
    @(negedge clk);
    ionReq = 1'b0; iofReq = 1'b0; skonReq = 1'b0;
  endtask

  task automatic boundary(input logic irqVal, input logic [W-1:0] pc);
    @(negedge clk);
    irq = irqVal; curPc = pc; instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
  endtask

  task automatic expectNone(input string req);
    repeat (3) begin
      @(negedge clk);
      check(!busy && !memReq, req, W'(busy), '0);
    end
  endtask

  task automatic entry(input logic [W-1:0] pc, input logic [W-1:0] vec, input string req);
    item_t it;
    int n;
    vecVal = vec;
    it.kind = 0; it.addr = 12'h000; it.data = pc;  it.req = {req, " R6"}; expQ.push_back(it);
    it.kind = 1; it.addr = 12'h001; it.data = '0;  it.req = {req, " R7"}; expQ.push_back(it);
    it.kind = 2; it.addr = '0;      it.data = vec; it.req = {req, " R8"}; expQ.push_back(it);
    @(negedge clk);
    irq = 1'b1; curPc = pc; instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    curPc = ~pc;
    check(busy && memReq && memWe, {req, " R11 busy after accept"}, W'(busy), 12'h001);
    n = 0;
    while (busy && n < 40) begin @(negedge clk); n++; end
    check(!busy, {req, " R11 busy drops"}, W'(busy), '0);
    check(expQ.size() == 0, {req, " R8 sequence complete"}, W'(expQ.size()), '0);
    expQ.delete();
  endtask

  initial begin
    #(20000 * 8);
    fails++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 12'h000, 12'h001);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !memReq && !pcLoad && !skip, "R1 reset outputs", {busy, memReq, pcLoad, skip}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReq && !pcLoad && !skip, "R1 after reset release", {busy, memReq, pcLoad, skip}, '0);

    // disabled: irq at boundary ignored
    boundary(1'b1, 12'h050);
    expectNone("R2 disabled boundary");

    // SKON while disabled: no skip, arms enable
    @(negedge clk); skonReq = 1'b1; #1;
    check(skip == 1'b0, "R10 skip clear when disabled", W'(skip), '0);
    @(negedge clk); skonReq = 1'b0; #1;
    check(skip == 1'b0, "R10 skip low without strobe", W'(skip), '0);

    // delayed enable: first boundary rejected, second accepted
    boundary(1'b1, 12'h060);
    expectNone("R4 boundary ending enabling instruction");
    waitStates = 0;
    entry(12'h123, 12'h456, "R4 second boundary");

    // enable cleared by entry
    boundary(1'b1, 12'h200);
    expectNone("R9 no nesting after entry");

    // ION then IOF before arming
    strobe(0);
    strobe(1);
    boundary(1'b1, 12'h300);
    boundary(1'b1, 12'h301);
    boundary(1'b1, 12'h302);
    expectNone("R5 disable cancels pending enable");

    // ION, let it arm with irq low, then irq without boundary
    strobe(0);
    boundary(1'b0, 12'h400);
    boundary(1'b0, 12'h401);
    @(negedge clk); irq = 1'b1;
    expectNone("R3 irq off boundary");
    irq = 1'b0;

    // SKON while enabled
    @(negedge clk); skonReq = 1'b1; #1;
    check(skip == 1'b1, "R10 skip set when enabled", W'(skip), 12'h001);
    @(negedge clk); skonReq = 1'b0;

    // enabled: immediate accept, wait states, extreme values
    waitStates = 2;
    entry(12'hFFF, 12'h000, "R7 wait states");

    // re-enable, then IOF after enable took effect
    waitStates = 1;
    strobe(0);
    boundary(1'b0, 12'h500);
    boundary(1'b0, 12'h501);
    strobe(1);
    boundary(1'b1, 12'h502);
    expectNone("R5 disable after enabled");

    // return path: ION, return jump completes, then pending irq taken
    strobe(0);
    boundary(1'b1, 12'h600);
    expectNone("R4 return jump not interrupted");
    entry(12'hA5A, 12'h7C3, "R4 accepted after return jump");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule